// File: doc/BRIEF.md
# Parallel DAC Bus Controller

This block is the host side of a 12-bit parallel converter bus. That bus has an active-low select line and a single direction line, where high means read and low means write. A request port accepts either a word to store in the converter or a command to read the stored word back. The controller then drives the select line, the direction line and the tri-state data lines in a fixed order. Every phase lasts at least the minimum time the converter needs. A readback ends with the captured word on a response port, marked by a one-cycle valid pulse.

All bus timing limits are parameters given in picoseconds, together with the system clock period. At elaboration, each limit becomes a cycle count by rounding up, and every count is at least one cycle. Each access passes through four phases: idle, setup, select low, and recovery. The controller accepts a new request only in the idle phase.

Top module: `pdac_bus_ctrl`

## Requirements
- R1: During and directly after a synchronous active-low reset, all of the following hold: select is high, the direction line is high (read level), the data output enable is low, `req_ready` is high and `rsp_valid` is low. A reset in the middle of an access abandons the access without a response pulse.
- R2: A write request stores its word in the converter register. A later readback returns exactly that word.
- R3: On a write, select stays low for at least T_CSLO_PS. The write word is driven, with the output enable high, for at least T_DSU_PS before select rises. The word and the enable are still present in the cycle in which select rises.
- R4: The direction line never changes in a cycle in which select changes.
- R5: On a read, the direction line has been high for at least T_RWCS_PS when select falls.
- R6: A read samples the data lines no earlier than T_ACC_PS after select falls. The sampled word appears on `rsp_rdata` together with a `rsp_valid` pulse that lasts exactly one cycle. Each read produces exactly one pulse and each write produces none.
- R7: Select stays high for at least T_CSHI_PS between two accesses.
- R8: The output enable is low whenever the direction line is high. It is low for at least one cycle before select falls for a read. After a read, the data lines are not driven again until T_RELQ_PS has passed since select rose.
- R9: `req_ready` is low from the cycle after a request is accepted until recovery ends. A request presented while `req_ready` is low is ignored.
- R10: With ceil(t/T) floored at one cycle, `req_ready` is low for exactly 1 + max(ceil(T_CSLO),ceil(T_DSU)) + ceil(T_CSHI) cycles for a write. For a read it is low for exactly ceil(T_RWCS) + max(ceil(T_ACC),ceil(T_CSLO)) + max(ceil(T_CSHI),ceil(T_RELQ)) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid is also high |
| req_write | input | 1 | 1 = write request, 0 = readback request |
| req_wdata | input | DATA_W | Word to write |
| rsp_valid | output | 1 | One-cycle pulse: readback word valid |
| rsp_rdata | output | DATA_W | Readback word |
| dac_sel_n | output | 1 | Converter select, active low |
| dac_rnw | output | 1 | Direction: 1 = read, 0 = write |
| dac_dq_out | output | DATA_W | Data driven toward the converter |
| dac_dq_oe | output | 1 | Output enable for the data lines |
| dac_dq_in | input | DATA_W | Data returned from the converter |

## Verification
The hardest case to reach from the ports is a read sampled too early. The data lines do hold some value, so a sample taken too early still returns a plausible-looking word. To expose this, the bench's converter model drives the bitwise complement of its register until just before the access limit has passed since select fell. An early sample therefore returns a wrong word. A second case needs deliberate timing: the bench asserts reset while select is low during a read. It then checks that the bus goes idle and that no response pulse appears.

// File: rtl/pdac_pkg.sv
`timescale 1ns/1ps
// Package: shared state type and elaboration-time helpers for the DAC bus controller.
// Assumes all timing values are non-negative picosecond figures.
package pdac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SELLO = 2'd2,
        ST_RECOV = 2'd3
    } seq_state_t;

    // Ceiling division of a time limit by the clock period, never below one cycle.
    function automatic int unsigned span_cycles(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned n;
        n = (t_ps + clk_ps - 1) / clk_ps;
        return (n < 1) ? 1 : n;
    endfunction

    // Larger of two counts.
    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pdac_timer.sv
`timescale 1ns/1ps
// Module: pdac_timer
// Loadable down-counter that measures the length of each bus phase.
// Assumes: load takes priority. The count rests at zero, and done is high while it is zero.
module pdac_timer #(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // Count register: load, or step down until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Expiry flag.
    always_comb done = (cnt_q == '0);

    // R10: an expired timer stays expired until reloaded
    a_r10_timer_rests: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && done) |=> done);

endmodule

// File: rtl/pdac_seq.sv
`timescale 1ns/1ps
// Module: pdac_seq
// Phase sequencer. It accepts a request in idle, drives select, direction and the
// data enable from its state, and flags the cycle in which read data is sampled.
// Assumes: phase lengths are counts of at least one, and the timer is loaded on every phase entry.
module pdac_seq
    import pdac_pkg::*;
#(
    parameter int unsigned DATA_W   = 12,
    parameter int unsigned CW       = 2,
    parameter int unsigned N_WR_SU  = 1,
    parameter int unsigned N_WR_LO  = 1,
    parameter int unsigned N_WR_REC = 1,
    parameter int unsigned N_RD_SU  = 1,
    parameter int unsigned N_RD_LO  = 2,
    parameter int unsigned N_RD_REC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              t_done,
    output logic              t_load,
    output logic [CW-1:0]     t_val,
    output logic              smp_en,
    output logic              dac_sel_n,
    output logic              dac_rnw,
    output logic              dac_dq_oe,
    output logic [DATA_W-1:0] dac_dq_out
);

    seq_state_t        state_q, state_d;
    logic              is_wr_q;
    logic [DATA_W-1:0] wdata_q;

    // State and latched command registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            is_wr_q <= 1'b0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                is_wr_q <= req_write;
                wdata_q <= req_wdata;
            end
        end
    end

    // Next phase, timer reload value and read-sample strobe.
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        smp_en  = 1'b0;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                state_d = ST_SETUP;
                t_load  = 1'b1;
                t_val   = req_write ? CW'(N_WR_SU - 1) : CW'(N_RD_SU - 1);
            end
            ST_SETUP: if (t_done) begin
                state_d = ST_SELLO;
                t_load  = 1'b1;
                t_val   = is_wr_q ? CW'(N_WR_LO - 1) : CW'(N_RD_LO - 1);
            end
            ST_SELLO: if (t_done) begin
                state_d = ST_RECOV;
                t_load  = 1'b1;
                t_val   = is_wr_q ? CW'(N_WR_REC - 1) : CW'(N_RD_REC - 1);
                smp_en  = !is_wr_q;
            end
            ST_RECOV: if (t_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Bus and handshake outputs decoded from the registered phase.
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        dac_sel_n  = (state_q != ST_SELLO);
        dac_dq_oe  = is_wr_q && (state_q != ST_IDLE);
        dac_rnw    = !dac_dq_oe;
        dac_dq_out = wdata_q;
    end

    // R4: direction steady across a falling select edge
    a_r4_dir_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sel_n) |-> $stable(dac_rnw));
    // R4: direction steady across a rising select edge
    a_r4_dir_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sel_n) |-> $stable(dac_rnw));
    // R8: no drive while the converter may be driving, and none in the cycle before
    a_r8_quiet_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_sel_n && dac_rnw) |-> (!dac_dq_oe && $past(!dac_dq_oe)));
    // R3: write word and enable still present when select rises
    a_r3_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dac_sel_n) && !dac_rnw) |-> (dac_dq_oe && $stable(dac_dq_out)));
    // R9: an idle controller leaves the bus released
    a_r9_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dac_sel_n && !dac_dq_oe));

endmodule

// File: rtl/pdac_rdcap.sv
`timescale 1ns/1ps
// Module: pdac_rdcap
// Captures the converter data lines on the sample strobe and raises a one-cycle response pulse.
// Assumes the strobe is never high in two consecutive cycles.
module pdac_rdcap #(
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic [DATA_W-1:0] dac_dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    // Response register: pulse plus held data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= smp_en;
            if (smp_en) rsp_rdata <= dac_dq_in;
        end
    end

    // R6: the response pulse lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/pdac_bus_ctrl.sv
`timescale 1ns/1ps
// Module: pdac_bus_ctrl (top)
// Host-side controller for a parallel converter bus. It turns picosecond limits into
// cycle counts and joins the sequencer, the phase timer and the readback capture.
// Assumes the clock period is at least 1 ps and the limits are fixed at elaboration.
module pdac_bus_ctrl
    import pdac_pkg::*;
#(
    parameter int unsigned DATA_W     = 12,
    parameter int unsigned CLK_PS     = 20000,
    parameter int unsigned T_CSLO_PS  = 10000,
    parameter int unsigned T_DSU_PS   = 6000,
    parameter int unsigned T_RWCS_PS  = 5000,
    parameter int unsigned T_CSHI_PS  = 9000,
    parameter int unsigned T_ACC_PS   = 40000,
    parameter int unsigned T_RELQ_PS  = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dac_sel_n,
    output logic              dac_rnw,
    output logic [DATA_W-1:0] dac_dq_out,
    output logic              dac_dq_oe,
    input  logic [DATA_W-1:0] dac_dq_in
);

    localparam int unsigned N_WR_SU  = 1;
    localparam int unsigned N_WR_LO  = umax(span_cycles(T_CSLO_PS, CLK_PS), span_cycles(T_DSU_PS, CLK_PS));
    localparam int unsigned N_WR_REC = span_cycles(T_CSHI_PS, CLK_PS);
    localparam int unsigned N_RD_SU  = span_cycles(T_RWCS_PS, CLK_PS);
    localparam int unsigned N_RD_LO  = umax(span_cycles(T_ACC_PS, CLK_PS), span_cycles(T_CSLO_PS, CLK_PS));
    localparam int unsigned N_RD_REC = umax(span_cycles(T_CSHI_PS, CLK_PS), span_cycles(T_RELQ_PS, CLK_PS));
    localparam int unsigned N_MAX    = umax(umax(umax(N_WR_LO, N_WR_REC), umax(N_RD_SU, N_RD_LO)), N_RD_REC);
    localparam int unsigned CW       = (N_MAX < 2) ? 1 : $clog2(N_MAX);

    logic          t_load, t_done, smp_en;
    logic [CW-1:0] t_val;

    pdac_seq #(
        .DATA_W(DATA_W), .CW(CW),
        .N_WR_SU(N_WR_SU), .N_WR_LO(N_WR_LO), .N_WR_REC(N_WR_REC),
        .N_RD_SU(N_RD_SU), .N_RD_LO(N_RD_LO), .N_RD_REC(N_RD_REC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready),
        .t_done(t_done), .t_load(t_load), .t_val(t_val),
        .smp_en(smp_en),
        .dac_sel_n(dac_sel_n), .dac_rnw(dac_rnw),
        .dac_dq_oe(dac_dq_oe), .dac_dq_out(dac_dq_out)
    );

    pdac_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .load(t_load), .load_val(t_val), .done(t_done)
    );

    pdac_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk(clk), .rst_n(rst_n),
        .smp_en(smp_en), .dac_dq_in(dac_dq_in),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // R9: no response pulse while the controller reports idle before any access
    a_r9_no_rsp_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && $past(req_ready)) |-> !rsp_valid);

endmodule

// File: tb/sim_pdac_bus_ctrl.sv
`timescale 1ns/1ps
// Bench for pdac_bus_ctrl. Contains a converter model on the bus, a vector table
// walked by one loop, a timing monitor, and directed tests for reset and ignored requests.
module sim_pdac_bus_ctrl;

    localparam int PER = 20;   // ns, 50 MHz
    localparam int W   = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [W-1:0] req_wdata = '0;
    logic         req_ready, rsp_valid, dac_sel_n, dac_rnw, dac_dq_oe;
    logic [W-1:0] rsp_rdata, dac_dq_out;
    logic [W-1:0] dac_dq_in = '0;
    logic [W-1:0] conv_reg = '0;

    int nchk = 0;
    int nfail = 0;

    always #(PER/2) clk = ~clk;

    pdac_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dac_sel_n(dac_sel_n), .dac_rnw(dac_rnw),
        .dac_dq_out(dac_dq_out), .dac_dq_oe(dac_dq_oe),
        .dac_dq_in(dac_dq_in)
    );

    function automatic int cyc(input int t_ns);
        int n = (t_ns + PER - 1) / PER;
        return (n < 1) ? 1 : n;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int WR_BUSY = 1 + ((cyc(10) > cyc(6)) ? cyc(10) : cyc(6)) + cyc(9);
    localparam int RD_BUSY = cyc(5) + ((cyc(40) > cyc(10)) ? cyc(40) : cyc(10))
                           + ((cyc(9) > cyc(10)) ? cyc(9) : cyc(10));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Converter model: the complement of the register until just before the access limit.
    always @(negedge dac_sel_n) begin
        dac_dq_in = ~conv_reg;
        #39.5;
        if (!dac_sel_n && dac_rnw) dac_dq_in = conv_reg;
    end
    always @(posedge dac_sel_n) dac_dq_in = ~conv_reg;

    // Bus timing monitor, sampled mid-cycle.
    logic         p_sel = 1'b1, p_rnw = 1'b1, p_oe = 1'b0;
    logic [W-1:0] p_dq = '0;
    int lo_run = 0, hi_run = 0, rhi_run = 0, dst_run = 0, since_rd = 0;
    bit seen = 0, rd_arm = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            seen = 0; rd_arm = 0; lo_run = 0; hi_run = 0; rhi_run = 0; dst_run = 0;
        end else begin
            if (p_sel != dac_sel_n) chk(dac_rnw == p_rnw, "R4", dac_rnw, p_rnw);
            if (!p_sel && dac_sel_n && !p_rnw) begin
                chk(lo_run * PER >= 10, "R3", lo_run * PER, 10);
                chk(dst_run * PER >= 6 && dac_dq_oe && dac_dq_out == p_dq, "R3", dst_run * PER, 6);
                conv_reg = p_dq;
            end
            if (!p_sel && dac_sel_n && p_rnw) begin since_rd = 0; rd_arm = 1; end
            if (p_sel && !dac_sel_n) begin
                if (seen) chk(hi_run * PER >= 9, "R7", hi_run * PER, 9);
                seen = 1;
                if (dac_rnw) begin
                    chk(rhi_run * PER >= 5, "R5", rhi_run * PER, 5);
                    chk(!p_oe && !dac_dq_oe, "R8", p_oe, 0);
                end
            end
            if (dac_dq_oe && !p_oe && rd_arm) begin
                chk(since_rd * PER >= 10, "R8", since_rd * PER, 10);
                rd_arm = 0;
            end
            if (dac_dq_oe && dac_rnw) chk(0, "R8", dac_dq_oe, 0);
            lo_run  = dac_sel_n ? 0 : lo_run + 1;
            hi_run  = dac_sel_n ? hi_run + 1 : 0;
            rhi_run = dac_rnw ? rhi_run + 1 : 0;
            dst_run = !dac_dq_oe ? 0 : ((!p_oe || dac_dq_out != p_dq) ? 1 : dst_run + 1);
            since_rd++;
        end
        p_sel = dac_sel_n; p_rnw = dac_rnw; p_oe = dac_dq_oe; p_dq = dac_dq_out;
    end

    // One full transaction: wait for ready, present for one cycle, count busy cycles.
    task automatic run_txn(input logic wr, input logic [W-1:0] d,
                           output logic [W-1:0] got, output int busy, output int pulses);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0; pulses = 0; got = '0;
        while (!req_ready && busy < 100) begin
            busy++;
            if (rsp_valid) begin pulses++; got = rsp_rdata; end
            @(negedge clk);
        end
    endtask

    // {write, data, expected readback}
    localparam int NV = 12;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 12'hABC, 12'h000}, {1'b0, 12'h000, 12'hABC},
        {1'b1, 12'h000, 12'h000}, {1'b0, 12'h000, 12'h000},
        {1'b1, 12'hFFF, 12'h000}, {1'b0, 12'h000, 12'hFFF},
        {1'b1, 12'h800, 12'h000}, {1'b1, 12'h7FF, 12'h000},
        {1'b0, 12'h000, 12'h7FF}, {1'b0, 12'h000, 12'h7FF},
        {1'b1, 12'h5A5, 12'h000}, {1'b0, 12'h000, 12'h5A5}
    };

    initial begin
        repeat (300000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [W-1:0] got;
        int busy, pulses;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(dac_sel_n == 1 && dac_rnw == 1 && dac_dq_oe == 0, "R1", {dac_sel_n, dac_rnw, dac_dq_oe}, 3'b110);
        chk(req_ready == 1 && rsp_valid == 0, "R1", {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dac_sel_n == 1 && req_ready == 1, "R1", {dac_sel_n, req_ready}, 2'b11);

        // Table walk: R2, R6, R10
        for (int i = 0; i < NV; i++) begin
            run_txn(VEC[i][24], VEC[i][23:12], got, busy, pulses);
            if (VEC[i][24]) begin
                chk(busy == WR_BUSY, "R10", busy, WR_BUSY);
                chk(pulses == 0, "R6", pulses, 0);
            end else begin
                chk(busy == RD_BUSY, "R10", busy, RD_BUSY);
                chk(pulses == 1, "R6", pulses, 1);
                chk(got == VEC[i][11:0], "R2", got, VEC[i][11:0]);
            end
        end

        // R9: a request shown only while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_wdata = 12'h3C3;
        @(negedge clk);
        req_wdata = 12'h111;
        chk(req_ready == 0, "R9", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        run_txn(1'b0, 12'h000, got, busy, pulses);
        chk(got == 12'h3C3, "R9", got, 12'h3C3);

        // R1: reset while select is low during a read
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(dac_sel_n == 0, "R1", dac_sel_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(dac_sel_n == 1 && dac_rnw == 1 && dac_dq_oe == 0 && req_ready == 1 && rsp_valid == 0,
            "R1", {dac_sel_n, dac_rnw, dac_dq_oe, req_ready, rsp_valid}, 5'b11010);
        rst_n = 1'b1;
        pulses = 0;
        repeat (6) begin @(negedge clk); if (rsp_valid) pulses++; end
        chk(pulses == 0, "R1", pulses, 0);

        // R2: the write before the reset is still readable
        run_txn(1'b0, 12'h000, got, busy, pulses);
        chk(got == 12'h3C3 && pulses == 1, "R2", got, 12'h3C3);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule